// File: doc/BRIEF.md
# SD/MMC Card Bring-Up Sequencer

This block is a hardware state machine that takes a freshly powered card from its idle state to the transfer state without software help. It drives a simple command-issue interface: it presents one command at a time (index, argument and expected response kind), then waits for the command engine to return a response word or an error. The command line protocol itself and the decoding of the card-specific data register live elsewhere. The sequencer only orders the commands, forms their arguments and checks the responses.

A single start pulse in idle begins the run. The sequencer first asks for the slow identification clock. It resets the card and checks whether the card echoes the interface-condition pattern. It then probes for an SD card with the application operating-condition command, and falls back to the MMC operating-condition command if that probe fails. Next it polls the chosen operating-condition command, with a programmable pause between attempts, until the card reports not-busy or an overall timeout runs out. It then reads the identification register, settles the relative card address, reads the card-specific data register and selects the card. On success it requests the fast transfer clock and pulses done. Any fatal command error ends the run in a fail state that requests the clock off and freezes the recorded card type, capacity class and address.

Top module: `sd_init_seq`

## Requirements
- R1: After reset the block is idle: clk_sel is 0 (off), busy, done, fail, cmd_valid, is_mmc and hi_cap are 0, and rca is 0.
- R2: A start pulse in idle clears fail, is_mmc, hi_cap and rca, sets clk_sel to 1 (identification rate) and issues command 0 with a zero argument and cmd_kind 0 (no response). A start pulse while busy is 1 has no effect on the command stream.
- R3: Command 8 follows with argument 0x1AA and cmd_kind 1 (48-bit response). If it returns without error and rsp_data[11:0] equals 0x1AA, bit 30 is set in every later polling argument; otherwise bit 30 is clear and the run continues.
- R4: Every command 41 is immediately preceded by command 55 with a zero argument; the first command 41 (the SD probe) carries a zero argument; both use cmd_kind 1.
- R5: If the probe's command 55 or command 41 returns an error, command 1 with a zero argument and cmd_kind 1 is issued; success marks is_mmc and forces bit 30 in polling arguments, while an error ends the run in fail.
- R6: Polling repeats (command 55 then 41 for SD, command 1 alone for MMC) with argument {1'b0, capacity bit, 6'b0, volt_win} until rsp_data[31] is 1; after a busy response the next polling command appears poll_gap + 1 cycles later than it would after a non-busy response.
- R7: If a busy polling response arrives once TIMEOUT_CYC or more cycles have passed since polling began, the run ends in fail.
- R8: On the not-busy polling response, hi_cap takes rsp_data[30].
- R9: Command 2 (zero argument, cmd_kind 2, 136-bit response) is followed by command 3 (cmd_kind 1). For SD its argument is zero and rca takes rsp_data[31:16]; for MMC its argument is 0x0001_0000 and rca becomes 1.
- R10: Command 9 (cmd_kind 2) and then command 7 (cmd_kind 3, response with busy) both carry rca in argument bits 31:16 and zero below.
- R11: When command 7 succeeds, done is high for exactly one cycle, clk_sel becomes 2 (transfer rate), busy falls and fail stays 0.
- R12: An error on any command other than command 8 or the SD probe pair ends the run: fail is set, clk_sel becomes 0, no further command is issued, and is_mmc, hi_cap and rca keep their values until the next start.
- R13: At most one command is outstanding: cmd_valid is a one-cycle pulse and is not raised again before the response to the previous command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run (taken only in idle) |
| volt_win | input | 24 | Voltage window placed in polling argument bits 23:0 |
| poll_gap | input | GAP_W | Pause in cycles between polling attempts |
| cmd_valid | output | 1 | One-cycle command issue strobe |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_kind | output | 2 | Response kind: 0 none, 1 48-bit, 2 136-bit, 3 48-bit with busy |
| rsp_valid | input | 1 | Response or error for the outstanding command |
| rsp_err | input | 1 | The outstanding command failed |
| rsp_data | input | 32 | Response status word |
| clk_sel | output | 2 | Requested card clock: 0 off, 1 identification, 2 transfer |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse on a successful run |
| fail | output | 1 | Last run failed; held until next start |
| is_mmc | output | 1 | Card answered as MMC |
| hi_cap | output | 1 | Card reported high capacity |
| rca | output | 16 | Relative card address |

## Verification
The bench runs the sequence against a behavioural card that answers as a modern SD card, an older SD card that rejects the interface-condition command, an SD card that echoes a wrong pattern, and an MMC card. Together these separate the capacity-bit decision from the card-type decision and from the reported capacity. Busy counts of zero, one and two, with several pause lengths, show that the polling loop repeats the right command pair and waits exactly the programmed pause. A card that never leaves busy exercises the timeout. Errors injected at the MMC probe and at the card-specific data read show which failures are fatal and that the recorded results freeze. A second start pulse mid-run shows that only idle accepts it.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_IFC, S_PAPP, S_PSD, S_PMMC,
    S_QAPP, S_QOP, S_GAP, S_CID, S_RCA, S_CSD, S_SEL
  } seq_st_t;

  localparam logic [1:0] RK_NONE  = 2'd0;
  localparam logic [1:0] RK_SHORT = 2'd1;
  localparam logic [1:0] RK_LONG  = 2'd2;
  localparam logic [1:0] RK_BUSY  = 2'd3;

  localparam logic [1:0] CK_OFF  = 2'd0;
  localparam logic [1:0] CK_ID   = 2'd1;
  localparam logic [1:0] CK_XFER = 2'd2;

  localparam logic [11:0] IFC_PATTERN = 12'h1AA;

  // polling argument: capacity request in bit 30, voltage window below
  function automatic logic [31:0] op_arg(input logic hcs, input logic [23:0] vw);
    return {1'b0, hcs, 6'b0, vw};
  endfunction

  // card address placed in the upper half of an argument
  function automatic logic [31:0] addr_arg(input logic [15:0] a);
    return {a, 16'h0000};
  endfunction

  function automatic logic echo_ok(input logic err, input logic [31:0] d);
    return !err && (d[11:0] == IFC_PATTERN);
  endfunction

  function automatic logic [5:0] cmd_of(input seq_st_t s, input logic mmc);
    case (s)
      S_IFC:          return 6'd8;
      S_PAPP, S_QAPP: return 6'd55;
      S_PSD:          return 6'd41;
      S_PMMC:         return 6'd1;
      S_QOP:          return mmc ? 6'd1 : 6'd41;
      S_CID:          return 6'd2;
      S_RCA:          return 6'd3;
      S_CSD:          return 6'd9;
      S_SEL:          return 6'd7;
      default:        return 6'd0;
    endcase
  endfunction

  function automatic logic [1:0] kind_of(input seq_st_t s);
    case (s)
      S_RST:        return RK_NONE;
      S_CID, S_CSD: return RK_LONG;
      S_SEL:        return RK_BUSY;
      default:      return RK_SHORT;
    endcase
  endfunction

endpackage

// File: rtl/sd_init_timer.sv
module sd_init_timer #(
  parameter int GAP_W       = 16,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_begin,
  input  logic             gap_load,
  input  logic [GAP_W-1:0] gap_len,
  output logic             gap_done,
  output logic             expired
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC);

  logic [GAP_W-1:0] gap_cnt;
  logic [TW-1:0]    age;
  logic             running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      age     <= '0;
      running <= 1'b0;
    end else begin
      if (gap_load)
        gap_cnt <= gap_len;
      else if (gap_cnt != '0)
        gap_cnt <= gap_cnt - 1'b1;

      if (poll_begin) begin
        age     <= '0;
        running <= 1'b1;
      end else if (running && age != LIMIT) begin
        age <= age + 1'b1;
      end
    end
  end

  assign gap_done = (gap_cnt == '0);
  assign expired  = running && (age >= LIMIT);
endmodule

// File: rtl/sd_init_fsm.sv
module sd_init_fsm
  import sd_init_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] volt_win,
  input  logic        rsp_valid,
  input  logic        rsp_err,
  input  logic [31:0] rsp_data,
  input  logic        gap_done,
  input  logic        expired,
  output logic        cmd_valid,
  output logic [5:0]  cmd_index,
  output logic [31:0] cmd_arg,
  output logic [1:0]  cmd_kind,
  output logic [1:0]  clk_sel,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic        is_mmc,
  output logic        hi_cap,
  output logic [15:0] rca,
  output logic        poll_begin,
  output logic        gap_load,
  output logic        ev_poll_busy
);
  seq_st_t     st;
  logic        waiting, hcs;
  logic        got, ok, bad, issue, fatal;

  assign issue = (st != S_IDLE) && (st != S_GAP) && !waiting;
  assign got   = waiting && rsp_valid;
  assign ok    = got && !rsp_err;
  assign bad   = got && rsp_err;
  // errors on the interface check and the SD probe pair are not fatal
  assign fatal = bad && !(st inside {S_IFC, S_PAPP, S_PSD});

  assign poll_begin   = ok && (st == S_PSD || st == S_PMMC);
  assign ev_poll_busy = ok && (st == S_QOP) && !rsp_data[31];
  assign gap_load     = ev_poll_busy && !expired;

  always_comb begin
    cmd_valid = issue;
    cmd_index = issue ? cmd_of(st, is_mmc) : 6'd0;
    cmd_kind  = issue ? kind_of(st) : RK_NONE;
    cmd_arg   = '0;
    if (issue) begin
      case (st)
        S_IFC:        cmd_arg = {20'h0, IFC_PATTERN};
        S_QOP:        cmd_arg = op_arg(hcs, volt_win);
        S_RCA:        cmd_arg = is_mmc ? addr_arg(16'd1) : '0;
        S_CSD, S_SEL: cmd_arg = addr_arg(rca);
        default:      cmd_arg = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      waiting <= 1'b0;
      hcs     <= 1'b0;
      is_mmc  <= 1'b0;
      hi_cap  <= 1'b0;
      rca     <= '0;
      clk_sel <= CK_OFF;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (issue) waiting <= 1'b1;
      if (got)   waiting <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_RST;
          clk_sel <= CK_ID;
          fail    <= 1'b0;
          is_mmc  <= 1'b0;
          hi_cap  <= 1'b0;
          rca     <= '0;
          hcs     <= 1'b0;
        end
        S_RST:  if (ok) st <= S_IFC;
        S_IFC:  if (got) begin
          hcs <= echo_ok(rsp_err, rsp_data);
          st  <= S_PAPP;
        end
        S_PAPP: if (ok) st <= S_PSD; else if (bad) st <= S_PMMC;
        S_PSD:  if (ok) st <= S_QAPP; else if (bad) st <= S_PMMC;
        S_PMMC: if (ok) begin
          is_mmc <= 1'b1;
          hcs    <= 1'b1;
          st     <= S_QOP;
        end
        S_QAPP: if (ok) st <= S_QOP;
        S_QOP:  if (ok) begin
          if (rsp_data[31]) begin
            hi_cap <= rsp_data[30];
            st     <= S_CID;
          end else if (expired) begin
            st      <= S_IDLE;
            fail    <= 1'b1;
            clk_sel <= CK_OFF;
          end else begin
            st <= S_GAP;
          end
        end
        S_GAP:  if (gap_done) st <= is_mmc ? S_QOP : S_QAPP;
        S_CID:  if (ok) st <= S_RCA;
        S_RCA:  if (ok) begin
          rca <= is_mmc ? 16'd1 : rsp_data[31:16];
          st  <= S_CSD;
        end
        S_CSD:  if (ok) st <= S_SEL;
        S_SEL:  if (ok) begin
          st      <= S_IDLE;
          done    <= 1'b1;
          clk_sel <= CK_XFER;
        end
        default: st <= S_IDLE;
      endcase
      if (fatal) begin
        st      <= S_IDLE;
        fail    <= 1'b1;
        clk_sel <= CK_OFF;
      end
    end
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq #(
  parameter int GAP_W       = 16,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      volt_win,
  input  logic [GAP_W-1:0] poll_gap,
  output logic             cmd_valid,
  output logic [5:0]       cmd_index,
  output logic [31:0]      cmd_arg,
  output logic [1:0]       cmd_kind,
  input  logic             rsp_valid,
  input  logic             rsp_err,
  input  logic [31:0]      rsp_data,
  output logic [1:0]       clk_sel,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             is_mmc,
  output logic             hi_cap,
  output logic [15:0]      rca
);
  // internal events, named for the bound checker
  logic ev_poll_begin, ev_gap_load, ev_gap_done, ev_expired, ev_poll_busy;

  sd_init_timer #(.GAP_W(GAP_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .poll_begin(ev_poll_begin), .gap_load(ev_gap_load), .gap_len(poll_gap),
    .gap_done(ev_gap_done), .expired(ev_expired)
  );

  sd_init_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .volt_win(volt_win),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .gap_done(ev_gap_done), .expired(ev_expired),
    .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_kind(cmd_kind),
    .clk_sel(clk_sel), .busy(busy), .done(done), .fail(fail),
    .is_mmc(is_mmc), .hi_cap(hi_cap), .rca(rca),
    .poll_begin(ev_poll_begin), .gap_load(ev_gap_load), .ev_poll_busy(ev_poll_busy)
  );
endmodule

// File: rtl/sd_init_chk.sv
module sd_init_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [5:0]  cmd_index,
  input logic [31:0] cmd_arg,
  input logic [1:0]  cmd_kind,
  input logic [1:0]  clk_sel,
  input logic        busy,
  input logic        done,
  input logic        fail,
  input logic        is_mmc,
  input logic        hi_cap,
  input logic [15:0] rca,
  input logic        ev_poll_busy,
  input logic        ev_expired
);
  // R13
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (clk_sel == 2'd2) && !busy && !fail);

  // R12
  fail_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (clk_sel == 2'd0) && !busy && !cmd_valid);

  // R12
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !$rose(fail)) |-> $stable(rca) && $stable(is_mmc) && $stable(hi_cap));

  // R3
  ifc_arg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_index == 6'd8) |-> (cmd_arg == 32'h0000_01AA) && (cmd_kind == 2'd1));

  // R10
  sel_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_index == 6'd7) |-> (cmd_kind == 2'd3) && (cmd_arg[15:0] == 16'h0));

  // R7
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_poll_busy && ev_expired) |=> fail);
endmodule

bind sd_init_seq sd_init_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
  .cmd_arg(cmd_arg), .cmd_kind(cmd_kind), .clk_sel(clk_sel), .busy(busy),
  .done(done), .fail(fail), .is_mmc(is_mmc), .hi_cap(hi_cap), .rca(rca),
  .ev_poll_busy(ev_poll_busy), .ev_expired(ev_expired)
);

// File: tb/test_sd_init_seq.sv
module test_sd_init_seq;
  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, rsp_valid, rsp_err;
  logic [31:0] rsp_data;
  logic [23:0] volt_win;
  logic [15:0] poll_gap;
  logic        cmd_valid, busy, done, fail, is_mmc, hi_cap;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic [1:0]  cmd_kind, clk_sel;
  logic [15:0] rca;

  sd_init_seq #(.GAP_W(16), .TIMEOUT_CYC(300)) i_sd_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .volt_win(volt_win), .poll_gap(poll_gap),
    .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_kind(cmd_kind),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .clk_sel(clk_sel), .busy(busy), .done(done), .fail(fail),
    .is_mmc(is_mmc), .hi_cap(hi_cap), .rca(rca)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // card personality
  bit c_mmc, c_v1, c_badecho, c_ccs, c_csderr, c_cmd1err, c_forever;
  int c_busy, busy_left;
  logic [15:0] c_rca;

  logic [39:0] expq[$];
  bit order_on, saw_cid, busy_pending, saw_done;
  int last_busy_cyc, exp_gap;

  task automatic chk(input bit good, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!good) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] idx);
    case (idx)
      6'd0:         return "R2";
      6'd8:         return "R3";
      6'd55, 6'd41: return "R4";
      6'd1:         return "R5";
      6'd2, 6'd3:   return "R9";
      default:      return "R10";
    endcase
  endfunction

  task automatic push(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind);
    expq.push_back({idx, kind, arg});
  endtask

  // expected command stream derived from the requirements
  task automatic build_exp();
    logic        hcs;
    logic [31:0] argp;
    logic [15:0] r;
    expq.delete();
    push(6'd0, 32'h0, 2'd0);
    push(6'd8, 32'h1AA, 2'd1);
    push(6'd55, 32'h0, 2'd1);
    if (!c_mmc) push(6'd41, 32'h0, 2'd1);
    else begin
      push(6'd1, 32'h0, 2'd1);
      if (c_cmd1err) return;
    end
    hcs  = c_mmc ? 1'b1 : (!c_v1 && !c_badecho);
    argp = {1'b0, hcs, 6'b0, volt_win};
    for (int i = 0; i <= c_busy; i++) begin
      if (!c_mmc) push(6'd55, 32'h0, 2'd1);
      push(c_mmc ? 6'd1 : 6'd41, argp, 2'd1);
    end
    r = c_mmc ? 16'd1 : c_rca;
    push(6'd2, 32'h0, 2'd2);
    push(6'd3, c_mmc ? 32'h0001_0000 : 32'h0, 2'd1);
    push(6'd9, {r, 16'h0}, 2'd2);
    if (c_csderr) return;
    push(6'd7, {r, 16'h0}, 2'd3);
  endtask

  task automatic card_answer(input logic [5:0] idx, input logic [31:0] arg,
                             output logic e, output logic [31:0] d, output bit was_busy);
    e = 1'b0; d = 32'h0; was_busy = 0;
    case (idx)
      6'd8:  if (c_mmc || c_v1) e = 1'b1;
             else d = c_badecho ? 32'h1AB : {20'h0, arg[11:0]};
      6'd55: if (c_mmc) e = 1'b1; else d = 32'h120;
      6'd41, 6'd1: begin
        if (idx == 6'd1 && c_cmd1err) e = 1'b1;
        else if (arg == 32'h0) d = 32'h00FF_8000;
        else if (c_forever || busy_left > 0) begin
          busy_left--; d = 32'h00FF_8000; was_busy = 1;
        end else d = 32'h80FF_8000 | (32'(c_ccs) << 30);
      end
      6'd2:  d = 32'h1234_5678;
      6'd3:  d = {c_rca, 16'h0500};
      6'd9:  e = c_csderr;
      default: d = 32'h0;
    endcase
  endtask

  // command monitor and card model: checks every issued command in order
  task automatic card_proc();
    logic        e;
    logic [31:0] d;
    logic [39:0] ex;
    bit          wb;
    forever begin
      @(negedge clk);
      if (rsp_valid) rsp_valid = 1'b0;
      if (cmd_valid) begin
        if (cmd_index == 6'd2) saw_cid = 1;
        if (busy_pending) begin
          chk(cyc - last_busy_cyc == exp_gap, "R6", "poll gap", 64'(cyc - last_busy_cyc), 64'(exp_gap));
          busy_pending = 0;
        end
        if (order_on) begin
          if (expq.size() == 0)
            chk(0, "R13", "unexpected command", 64'(cmd_index), 64'h0);
          else begin
            ex = expq.pop_front();
            chk({cmd_index, cmd_kind, cmd_arg} == ex, tag_of(ex[39:34]), "command",
                64'({cmd_index, cmd_kind, cmd_arg}), 64'(ex));
          end
        end
        card_answer(cmd_index, cmd_arg, e, d, wb);
        repeat (2) @(negedge clk);
        rsp_err = e; rsp_data = d; rsp_valid = 1'b1;
        if (wb) begin busy_pending = 1; last_busy_cyc = cyc; end
      end
    end
  endtask

  task automatic set_card(input bit mmc, input bit v1, input bit bad_echo, input bit ccs,
                          input bit csderr, input bit cmd1err, input bit forever_busy,
                          input int nbusy, input logic [15:0] r, input logic [15:0] gap);
    c_mmc = mmc; c_v1 = v1; c_badecho = bad_echo; c_ccs = ccs; c_csderr = csderr;
    c_cmd1err = cmd1err; c_forever = forever_busy; c_busy = nbusy; busy_left = nbusy;
    c_rca = r; poll_gap = gap; exp_gap = int'(gap) + 2;
    busy_pending = 0; saw_cid = 0; saw_done = 0;
  endtask

  task automatic run(input bit track, input bit poke_mid);
    order_on = track;
    if (track) build_exp();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(fail == 1'b0 && clk_sel == 2'd1 && busy, "R2", "start accepted",
        64'({fail, clk_sel, busy}), 64'({1'b0, 2'd1, 1'b1}));
    if (poke_mid) begin
      repeat (9) @(negedge clk);
      start = 1'b1;               // R2: ignored while busy
      @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 5000 && !(done || fail); i++) @(negedge clk);
    saw_done = done;
    if (done) begin
      @(negedge clk);
      chk(!done, "R11", "done one cycle", 64'(done), 64'h0);
    end
    repeat (30) @(negedge clk);
    if (track) chk(expq.size() == 0, "R13", "commands left", 64'(expq.size()), 64'h0);
  endtask

  task automatic check_ok(input bit mmc, input bit hc, input logic [15:0] r);
    chk(saw_done, "R11", "done seen", 64'(saw_done), 64'h1);
    chk(clk_sel == 2'd2 && !busy && !fail, "R11", "transfer clock",
        64'({clk_sel, busy, fail}), 64'({2'd2, 2'b00}));
    chk(is_mmc == mmc, "R5", "card type", 64'(is_mmc), 64'(mmc));
    chk(hi_cap == hc, "R8", "capacity class", 64'(hi_cap), 64'(hc));
    chk(rca == r, "R9", "address", 64'(rca), 64'(r));
  endtask

  task automatic check_fail(input string req, input bit mmc, input bit hc, input logic [15:0] r);
    chk(fail && !saw_done && clk_sel == 2'd0 && !busy, req, "fail state",
        64'({fail, saw_done, clk_sel, busy}), 64'({1'b1, 1'b0, 2'd0, 1'b0}));
    chk(is_mmc == mmc && hi_cap == hc && rca == r, "R12", "held results",
        64'({is_mmc, hi_cap, rca}), 64'({mmc, hc, r}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0; rsp_data = '0;
    volt_win = 24'hFF8000; poll_gap = '0; order_on = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail && !cmd_valid && clk_sel == 2'd0, "R1", "reset controls",
        64'({busy, done, fail, cmd_valid, clk_sel}), 64'h0);
    chk(!is_mmc && !hi_cap && rca == 16'h0, "R1", "reset results",
        64'({is_mmc, hi_cap, rca}), 64'h0);
    fork card_proc(); join_none

    // modern SD, two busy replies, pause 5
    set_card(0, 0, 0, 1, 0, 0, 0, 2, 16'hB00C, 16'd5);
    run(1, 0); check_ok(0, 1, 16'hB00C);

    // older SD rejects interface check; second start mid-run (R2)
    set_card(0, 1, 0, 0, 0, 0, 0, 1, 16'h4321, 16'd0);
    run(1, 1); check_ok(0, 0, 16'h4321);

    // wrong echo: no capacity request (R3), card still reports high capacity
    set_card(0, 0, 1, 1, 0, 0, 0, 0, 16'h0042, 16'd3);
    run(1, 0); check_ok(0, 1, 16'h0042);

    // MMC card through the fallback probe
    set_card(1, 0, 0, 1, 0, 0, 0, 2, 16'hFFFF, 16'd4);
    run(1, 0); check_ok(1, 1, 16'h0001);

    // error on CSD read ends in fail with results frozen
    set_card(0, 0, 0, 1, 1, 0, 0, 0, 16'h7777, 16'd2);
    run(1, 0); check_fail("R12", 0, 1, 16'h7777);

    // card never leaves busy: overall timeout
    volt_win = 24'h300000;
    set_card(0, 0, 0, 0, 0, 0, 1, 0, 16'h1111, 16'd20);
    run(0, 0); check_fail("R7", 0, 0, 16'h0000);
    chk(!saw_cid, "R7", "no identification after timeout", 64'(saw_cid), 64'h0);

    // MMC probe error is fatal
    volt_win = 24'hFF8000;
    set_card(1, 0, 0, 0, 0, 1, 0, 0, 16'h2222, 16'd1);
    run(1, 0); check_fail("R5", 0, 0, 16'h0000);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule